// File: doc/BRIEF.md
# Glitch-Free Gated Clock Output Bank

This block fans one source clock out to a bank of six single-ended clock outputs. Each output stands in for one differential pair. Every output has its own asynchronous active-high enable pin and its own register enable bit. An output runs only while both are set and the global active-low power-down input is released.

Enable pins and the power-down input are resynchronised to the source clock through a short flop chain. The synchronised pin is combined with the register bit and the power-down state. That combined request is then captured by a falling-edge flop. Because of this, a gate can only open or close while the source clock is low. Every pulse that reaches an output is therefore a complete source high phase, and a stopped output rests at logic low.

Top module: `gated_clk_bank`

## Requirements
- R1: While reset is asserted, and after its release until an output's enable path is set, every output stays at logic low.
- R2: An output whose pin is 1 and whose register bit is 1, with power-down released (input at 1), toggles with the source clock. It is high in each source high phase and low in each low phase.
- R3: Clearing an output's enable pin stops that output within a few cycles. Other outputs are unaffected.
- R4: Clearing an output's register bit stops that output even while its pin stays 1.
- R5: A stopped output is held at logic low through both clock phases.
- R6: Every high pulse on every output lasts exactly one source high phase (5 ns at the bench clock). Pulses are never truncated or stretched, including when the output starts or stops.
- R7: After an enable pin rises, with the register bit and power-down already allowing it, the output shows its first high phase within 2 to 6 source rising edges.
- R8: Driving the power-down input to 0 stops all six outputs, whatever the individual enables are.
- R9: When power-down returns to 1, each output again follows the AND of its own pin and register bit.
- R10: Bit i of the pin vector, the register vector and the output vector all refer to the same output channel. Channels do not interact.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_src | input | 1 | Source clock that is fanned out |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_pin | input | 6 | Asynchronous per-output enable pins, active high |
| en_bit | input | 6 | Per-output register enable bits, synchronous to clk_src |
| pwrdn_n | input | 1 | Asynchronous global power-down, active low |
| clk_out | output | 6 | Gated clock outputs, low when stopped |

## Verification
The bench changes inputs 2 ns after a rising edge. A pin or power-down change then passes two rising-edge flops and one falling-edge capture, so the first affected high phase comes at the third rising edge after the change. A register-bit change shows up at the very next high phase. Table checks wait eight cycles after each stimulus before they sample the outputs, once 2 ns into a high phase and once 2 ns into a low phase. The latency test counts rising edges after the pin change and takes the first cycle whose high-phase sample is 1. A monitor timestamps every output edge, so that each pulse width can be compared with the 5 ns high phase.

// File: rtl/gated_clk_bank.sv
module gated_clk_bank #(
  parameter int NUM_OUT     = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk_src,
  input  logic               rst_n,
  input  logic [NUM_OUT-1:0] en_pin,
  input  logic [NUM_OUT-1:0] en_bit,
  input  logic               pwrdn_n,
  output logic [NUM_OUT-1:0] clk_out
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0][NUM_OUT-1:0] pin_sync;
  logic [SYNC_STAGES-1:0]              pd_sync;
  logic [NUM_OUT-1:0]                  run_req;
  logic [NUM_OUT-1:0]                  gate_q;

  always_ff @(posedge clk_src or negedge rst_n) begin
    if (!rst_n) begin
      pin_sync <= '0;
      pd_sync  <= '0;
    end else begin
      pin_sync <= {pin_sync[SYNC_STAGES-2:0], en_pin};
      pd_sync  <= {pd_sync[SYNC_STAGES-2:0], pwrdn_n};
    end
  end

  assign run_req = pin_sync[LAST] & en_bit & {NUM_OUT{pd_sync[LAST]}};

  // captured while the clock falls, so gates only move during the low phase
  always_ff @(negedge clk_src or negedge rst_n) begin
    if (!rst_n) gate_q <= '0;
    else        gate_q <= run_req;
  end

  assign clk_out = gate_q & {NUM_OUT{clk_src}};

endmodule

// File: rtl/gated_clk_bank_chk.sv
module gated_clk_bank_chk #(
  parameter int NUM_OUT     = 6,
  parameter int SYNC_STAGES = 2
) (
  input logic               clk_src,
  input logic               rst_n,
  input logic [NUM_OUT-1:0] en_pin,
  input logic               pwrdn_n,
  input logic [NUM_OUT-1:0] gate_q,
  input logic [NUM_OUT-1:0] clk_out
);

  // R5: output is low whenever the source clock is low
  a_r5_low_phase: assert property (@(posedge clk_src) disable iff (!rst_n)
    clk_out == '0);

  // R8: power-down seen SYNC_STAGES edges ago keeps every gate closed
  a_r8_pd_stops: assert property (@(posedge clk_src) disable iff (!rst_n)
    !$past(pwrdn_n, SYNC_STAGES) |-> gate_q == '0);

  // R3: a gate may be open only if its pin was high SYNC_STAGES edges ago
  a_r3_pin_gates: assert property (@(posedge clk_src) disable iff (!rst_n)
    (gate_q & ~$past(en_pin, SYNC_STAGES)) == '0);

  // R6: outputs rise only with the clock high and fall only with it low
  logic [NUM_OUT-1:0] prev_out = '0;
  always @(clk_out) begin
    if (rst_n) begin
      a_r6_rise_aligned: assert ((clk_out & ~prev_out) == '0 || clk_src);
      a_r6_fall_aligned: assert ((~clk_out & prev_out) == '0 || !clk_src);
    end
    prev_out = clk_out;
  end

endmodule

bind gated_clk_bank gated_clk_bank_chk #(.NUM_OUT(NUM_OUT), .SYNC_STAGES(SYNC_STAGES)) u_chk (
  .clk_src(clk_src), .rst_n(rst_n), .en_pin(en_pin),
  .pwrdn_n(pwrdn_n), .gate_q(gate_q), .clk_out(clk_out));

// File: tb/sim_gated_clk_bank.sv
`timescale 1ns/1ps
module sim_gated_clk_bank;
  localparam int N = 6;
  localparam int NV = 10;
  // each entry: {pin, bit, pwrdn_n, expected running outputs}
  localparam logic [18:0] VEC [NV] = '{
    {6'h3F, 6'h3F, 1'b1, 6'h3F},  // R2 all running
    {6'h3F, 6'h00, 1'b1, 6'h00},  // R4 register bits clear
    {6'h00, 6'h3F, 1'b1, 6'h00},  // R3 pins clear
    {6'h2A, 6'h3F, 1'b1, 6'h2A},  // R10 alternate pins
    {6'h3F, 6'h15, 1'b1, 6'h15},  // R10 alternate bits
    {6'h0F, 6'h3C, 1'b1, 6'h0C},  // R2 AND of both
    {6'h3F, 6'h3F, 1'b0, 6'h00},  // R8 power-down
    {6'h33, 6'h3F, 1'b1, 6'h33},  // R9 release follows own enable
    {6'h01, 6'h01, 1'b1, 6'h01},  // R10 lowest channel
    {6'h20, 6'h20, 1'b1, 6'h20}   // R10 highest channel
  };

  logic clk = 0, rst_n = 0, pwrdn_n = 1;
  logic [N-1:0] en_pin = '1, en_bit = '1;
  logic [N-1:0] clk_out;
  int errors = 0, checks = 0, pulses = 0, bad_pulses = 0;
  bit done = 0;

  always #5 clk = ~clk;

  gated_clk_bank u0 (.clk_src(clk), .rst_n(rst_n), .en_pin(en_pin),
                     .en_bit(en_bit), .pwrdn_n(pwrdn_n), .clk_out(clk_out));

  realtime rise_t [N];
  logic [N-1:0] prev = '0;
  always @(clk_out) begin
    for (int i = 0; i < N; i++) begin
      if (clk_out[i] && !prev[i]) rise_t[i] = $realtime;
      if (!clk_out[i] && prev[i]) begin
        pulses++;
        if ($realtime - rise_t[i] != 5.0) bad_pulses++;
      end
    end
    prev = clk_out;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic sample(output logic [N-1:0] hi, output logic [N-1:0] lo);
    @(posedge clk); #2 hi = clk_out;
    @(negedge clk); #2 lo = clk_out;
  endtask

  task automatic drive(input logic [N-1:0] p, input logic [N-1:0] b, input logic pd);
    @(posedge clk); #2;
    en_pin = p; en_bit = b; pwrdn_n = pd;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [N-1:0] hi, lo;
    int lat;
    // R1: reset holds outputs low with all enables set
    for (int c = 0; c < 4; c++) begin
      sample(hi, lo);
      check(hi == 0 && lo == 0, "R1 reset", hi, 0);
    end
    @(posedge clk); #2 rst_n = 1;
    sample(hi, lo);
    check(hi == 0, "R1 first cycle after reset", hi, 0);

    for (int v = 0; v < NV; v++) begin
      drive(VEC[v][18:13], VEC[v][12:7], VEC[v][6]);
      repeat (8) @(posedge clk);
      sample(hi, lo);
      check(hi == VEC[v][5:0], $sformatf("R2 vector %0d high phase", v), hi, VEC[v][5:0]);
      check(lo == 0, $sformatf("R5 vector %0d low phase", v), lo, 0);
    end

    // R7: resume latency on channel 0
    drive(6'h3E, 6'h3F, 1'b1);
    repeat (8) @(posedge clk);
    sample(hi, lo);
    check(hi == 6'h3E, "R5 channel 0 parked", hi, 6'h3E);
    @(posedge clk); #2 en_pin = 6'h3F;
    lat = 0;
    for (int c = 1; c <= 10 && lat == 0; c++) begin
      @(posedge clk); #2;
      if (clk_out[0]) lat = c;
    end
    check(lat >= 2 && lat <= 6, "R7 resume latency", lat, 3);

    // R3: stop channel 0 by pin, others keep running
    drive(6'h3E, 6'h3F, 1'b1);
    repeat (6) @(posedge clk);
    sample(hi, lo);
    check(hi == 6'h3E && lo == 0, "R3 pin stop", hi, 6'h3E);

    // R4: stop channel 5 by register bit with pin still high
    drive(6'h3F, 6'h1F, 1'b1);
    repeat (2) @(posedge clk);
    sample(hi, lo);
    check(hi == 6'h1F, "R4 bit stop", hi, 6'h1F);

    // R8/R9: power-down pulse, then recovery
    drive(6'h3F, 6'h3F, 1'b0);
    repeat (6) @(posedge clk);
    sample(hi, lo);
    check(hi == 0, "R8 power-down", hi, 0);
    drive(6'h3F, 6'h3F, 1'b1);
    repeat (6) @(posedge clk);
    sample(hi, lo);
    check(hi == 6'h3F, "R9 recovery", hi, 6'h3F);

    // R6: every pulse seen was exactly one high phase
    check(pulses > 100, "R6 pulses observed", pulses, 100);
    check(bad_pulses == 0, "R6 pulse width", bad_pulses, 0);

    done = 1;
    summary();
    $finish;
  end
endmodule